// File: doc/BRIEF.md
# PWM Time-Base Counter with Two-Stage Prescaler

This block is the timing backbone of a pulse-width modulator. A 16-bit counter advances once for every terminal tick of a clock prescaler. The prescaler's divide is the product of a power-of-two stage and a linear even stage. The counter can count upward, downward, up and then down, or be frozen. Its turning point comes from a period register, which is loaded either at once or through a shadow copy that takes effect when the counter reaches zero.

A run field decides whether the counter keeps going, halts at once, or finishes its cycle down to zero and then stays there. The counter value, its direction, and one-cycle strobes for zero and period matches go to the compare and action logic downstream. A single write port carries the control word and the period value.

Top module: `pwm_timebase`

## Requirements
- R1: With counter mode 00 (up) the counter goes from 0 up to the active period, wrapping to 0 on the advance after it reaches the period, or on any advance at which it is already above the period.
- R2: With counter mode 01 (down) the counter decrements on each advance and reloads the active period on the advance after it reaches 0.
- R3: With counter mode 10 (up-down) the counter reverses at the period and at 0. Leaving the period it steps to period-1, and leaving 0 it steps to 1. With a period of 0 it stays at 0.
- R4: With counter mode 11 (freeze) the counter holds its value.
- R5: The control word (wr_sel=0) holds the run mode in [15:14], the period-load bit in [3] and the counter mode in [1:0]. Its two prescaler fields are c in [12:10] and h in [9:7]. One advance happens every 2^c × (h==0 ? 1 : 2h) clock cycles, counted from reset or from the last divide change.
- R6: When the period-load bit is 0, a period write (wr_sel=1) goes to a shadow register. The shadow is copied to the active period on each prescaler tick at which the counter equals 0.
- R7: When the period-load bit is 1, a period write updates the active period on the next clock edge.
- R8: zero_evt is high for exactly the cycles that hold a prescaler tick while the counter equals 0. prd_evt does the same for the counter equal to the active period. Both are produced in every counter and run mode.
- R9: dir_up is 1 in up mode and 0 in down mode. In up-down and freeze modes it shows the current up-down direction, which is 1 after reset.
- R10: After reset the counter, active period and shadow are 0, and the control word is 0: stopped, up mode, shadow load, divide by 1.
- R11: Run mode 00 makes no further counter advances; the counter holds its value.
- R12: Run mode 01 keeps advancing until an advance brings the counter to 0 and then holds it, even if 01 is written again. Holding ends only when run mode 11, or 10 (which acts as free run), is written.
- R13: A control write whose prescaler fields differ from the current ones restarts the prescaler count. A write with the same fields leaves the count running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| wr_sel | input | 1 | 0 selects the control word, 1 selects the period |
| wr_data | input | 16 | Write data |
| cnt | output | CNT_W | Counter value |
| zero_evt | output | 1 | Zero-match strobe |
| prd_evt | output | 1 | Period-match strobe |
| dir_up | output | 1 | Counting direction, 1 for up |

## Verification
Most internal faults show at the ports within one prescaler interval.

- **Wrong prescaler count:** the spacing of counter steps and event strobes shifts on the very next tick.
- **Wrong active or shadow period:** it shows as a wrong turning point within one counter cycle. In shadow mode it shows only after the next zero match.
- **Stuck direction or halt flag:** it shows as a counter that moves the wrong way, or one that fails to hold, at the next advance.

The bench runs a cycle-accurate model beside the design and compares every output on every cycle. Stale state therefore cannot stay hidden behind later activity.

// File: rtl/pwm_timebase.sv
module pwm_timebase #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             wr_sel,
  input  logic [15:0]      wr_data,
  output logic [CNT_W-1:0] cnt,
  output logic             zero_evt,
  output logic             prd_evt,
  output logic             dir_up
);
  localparam int PS_W = 12;

  logic [1:0]       run_q, mode_q;
  logic             ld_imm_q;
  logic [2:0]       cdiv_q, hdiv_q;
  logic [PS_W-1:0]  pcnt_q, div;
  logic [3:0]       hs;
  logic [CNT_W-1:0] prd_act_q, prd_sh_q, cnt_q, cnt_nx;
  logic             ud_dir_q, dir_nx, halted_q;
  logic             tick, advance, wr_ctrl, wr_prd, div_chg;

  assign hs      = (hdiv_q == 3'd0) ? 4'd1 : {hdiv_q, 1'b0};
  assign div     = PS_W'(hs) << cdiv_q;
  assign tick    = (pcnt_q == div - 1'b1);
  assign wr_ctrl = wr_en && !wr_sel;
  assign wr_prd  = wr_en && wr_sel;
  assign div_chg = wr_ctrl && (wr_data[12:7] != {cdiv_q, hdiv_q});
  assign advance = tick && (mode_q != 2'b11) &&
                   (run_q[1] || (run_q == 2'b01 && !halted_q));

  assign cnt      = cnt_q;
  assign zero_evt = tick && (cnt_q == '0);
  assign prd_evt  = tick && (cnt_q == prd_act_q);
  assign dir_up   = (mode_q == 2'b00) ? 1'b1 :
                    (mode_q == 2'b01) ? 1'b0 : ud_dir_q;

  always_comb begin
    cnt_nx = cnt_q;
    dir_nx = ud_dir_q;
    case (mode_q)
      2'b00: cnt_nx = (cnt_q >= prd_act_q) ? '0 : cnt_q + 1'b1;
      2'b01: cnt_nx = (cnt_q == '0) ? prd_act_q : cnt_q - 1'b1;
      2'b10: begin
        if (ud_dir_q) begin
          if (cnt_q >= prd_act_q) begin
            dir_nx = 1'b0;
            cnt_nx = (cnt_q == '0) ? '0 : cnt_q - 1'b1;
          end else begin
            cnt_nx = cnt_q + 1'b1;
          end
        end else begin
          if (cnt_q == '0) begin
            dir_nx = 1'b1;
            cnt_nx = (prd_act_q == '0) ? '0 : CNT_W'(1);
          end else begin
            cnt_nx = cnt_q - 1'b1;
          end
        end
      end
      default: cnt_nx = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pcnt_q <= '0;
    end else if (div_chg || tick) begin
      pcnt_q <= '0;
    end else begin
      pcnt_q <= pcnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q    <= 2'b00;
      mode_q   <= 2'b00;
      ld_imm_q <= 1'b0;
      cdiv_q   <= 3'd0;
      hdiv_q   <= 3'd0;
    end else if (wr_ctrl) begin
      run_q    <= wr_data[15:14];
      mode_q   <= wr_data[1:0];
      ld_imm_q <= wr_data[3];
      cdiv_q   <= wr_data[12:10];
      hdiv_q   <= wr_data[9:7];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prd_sh_q  <= '0;
      prd_act_q <= '0;
    end else begin
      if (wr_prd) prd_sh_q <= wr_data[CNT_W-1:0];
      if (wr_prd && ld_imm_q)
        prd_act_q <= wr_data[CNT_W-1:0];
      else if (!ld_imm_q && zero_evt)
        prd_act_q <= prd_sh_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      ud_dir_q <= 1'b1;
      halted_q <= 1'b0;
    end else begin
      if (advance) begin
        cnt_q    <= cnt_nx;
        ud_dir_q <= dir_nx;
      end
      if (run_q[1])
        halted_q <= 1'b0;
      else if (advance && run_q == 2'b01 && cnt_nx == '0)
        halted_q <= 1'b1;
    end
  end
endmodule

module pwm_timebase_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic             wr_sel,
  input logic [15:0]      wr_data,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] prd_act,
  input logic [1:0]       mode,
  input logic [1:0]       run,
  input logic             ld_imm,
  input logic             zero_evt,
  input logic             prd_evt
);
  p_freeze_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b11) |=> $stable(cnt));

  p_stopped_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (run == 2'b00) |=> $stable(cnt));

  p_up_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b00 && run[1]) |=>
      (cnt == $past(cnt) || cnt == CNT_W'($past(cnt) + 1'b1) || cnt == '0));

  p_down_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b01 && run[1]) |=>
      (cnt == $past(cnt) || cnt == CNT_W'($past(cnt) - 1'b1) || cnt == $past(prd_act)));

  p_imm_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel && ld_imm) |=> (prd_act == $past(wr_data[CNT_W-1:0])));

  p_both_evt_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (zero_evt && prd_evt) |-> (prd_act == '0));
endmodule

bind pwm_timebase pwm_timebase_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
  .cnt(cnt_q), .prd_act(prd_act_q), .mode(mode_q), .run(run_q),
  .ld_imm(ld_imm_q), .zero_evt(zero_evt), .prd_evt(prd_evt)
);

// File: tb/test_pwm_timebase.sv
module test_pwm_timebase;
  localparam int CLK_PERIOD = 10;
  localparam int W = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0, wr_sel = 1'b0;
  logic [15:0] wr_data = '0;
  logic [W-1:0] cnt;
  logic zero_evt, prd_evt, dir_up;

  int n_chk = 0, n_bad = 0;
  string tag = "R10";

  always #(CLK_PERIOD/2) clk = ~clk;

  pwm_timebase #(.CNT_W(W)) i_pwm_timebase (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .cnt(cnt), .zero_evt(zero_evt), .prd_evt(prd_evt), .dir_up(dir_up));

  logic [1:0] m_run, m_mode;
  logic m_imm, m_udir, m_halt;
  logic [2:0] m_c, m_h;
  int m_pc;
  logic [W-1:0] m_cnt, m_prd, m_sh;

  function automatic int divide(input logic [2:0] c, input logic [2:0] h);
    return (h == 0 ? 1 : 2 * int'(h)) << c;
  endfunction

  function automatic logic m_tick();
    return m_pc == divide(m_c, m_h) - 1;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_run = 0; m_mode = 0; m_imm = 0; m_c = 0; m_h = 0;
      m_pc = 0; m_cnt = 0; m_prd = 0; m_sh = 0; m_udir = 1; m_halt = 0;
    end else begin
      logic t, adv, nd;
      logic [W-1:0] nc;
      t = m_tick();
      adv = t && m_mode != 3 && (m_run[1] || (m_run == 1 && !m_halt));
      nc = m_cnt; nd = m_udir;
      case (m_mode)
        0: nc = (m_cnt >= m_prd) ? 0 : m_cnt + 1;
        1: nc = (m_cnt == 0) ? m_prd : m_cnt - 1;
        2: if (m_udir) begin
             if (m_cnt >= m_prd) begin nd = 0; nc = (m_cnt == 0) ? 0 : m_cnt - 1; end
             else nc = m_cnt + 1;
           end else begin
             if (m_cnt == 0) begin nd = 1; nc = (m_prd == 0) ? 0 : 1; end
             else nc = m_cnt - 1;
           end
        default: ;
      endcase
      if (m_run[1]) m_halt = 0;
      else if (adv && m_run == 1 && nc == 0) m_halt = 1;
      if (adv) begin m_cnt = nc; m_udir = nd; end
      if (wr_en && wr_sel && m_imm) m_prd = wr_data;
      else if (!m_imm && t && m_cnt_was_zero(t)) m_prd = m_sh;
      if (wr_en && wr_sel) m_sh = wr_data;
      if ((wr_en && !wr_sel && wr_data[12:7] != {m_c, m_h}) || t) m_pc = 0;
      else m_pc = m_pc + 1;
      if (wr_en && !wr_sel) begin
        m_run = wr_data[15:14]; m_mode = wr_data[1:0]; m_imm = wr_data[3];
        m_c = wr_data[12:10]; m_h = wr_data[9:7];
      end
    end
  end

  logic m_zero_pre;
  always @(negedge clk) m_zero_pre = (m_cnt == 0);
  function automatic logic m_cnt_was_zero(input logic t);
    return t && m_zero_pre;
  endfunction

  task automatic check(input string tg, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", tg, what, act, exp, $time);
    end
  endtask

  task automatic compare();
    logic t;
    t = m_tick();
    check(tag, "cnt", cnt, m_cnt);
    check("R8", "zero_evt", zero_evt, t && m_cnt == 0);
    check("R8", "prd_evt", prd_evt, t && m_cnt == m_prd);
    check("R9", "dir_up", dir_up, m_mode == 0 ? 1 : (m_mode == 1 ? 0 : m_udir));
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
      wr_en = 0;
      compare();
    end
  endtask

  task automatic wr(input logic sel, input logic [15:0] d);
    wr_en = 1; wr_sel = sel; wr_data = d;
    step(1);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h1234_5678));
    repeat (3) @(negedge clk);
    rst_n = 1;
    step(1);
    check("R10", "cnt after reset", cnt, 0);
    check("R10", "dir_up after reset", dir_up, 1);
    step(5);
    tag = "R7";  wr(0, 16'hC008); wr(1, 16'd9); step(30);
    check("R7", "cnt bounded by new period", (cnt <= 9) ? 1 : 0, 1);
    tag = "R1";  wr(0, 16'hC000); step(30);
    tag = "R6";  wr(1, 16'd4); step(40);
    tag = "R2";  wr(0, 16'hC001); step(40);
    tag = "R3";  wr(0, 16'hC00A); wr(1, 16'd6); wr(0, 16'hC002); step(50);
    tag = "R5";  wr(0, 16'hC582); step(200);
    tag = "R13"; step(5); wr(0, 16'hC582); step(7); wr(0, 16'hC102); step(60);
    tag = "R4";  wr(0, 16'hC003); step(20);
    tag = "R11"; wr(0, 16'hC000); step(10); wr(0, 16'h0000); step(20);
    tag = "R12"; wr(0, 16'hC000); step(3); wr(0, 16'h4000); step(40);
    check("R12", "held at zero", cnt, 0);
    wr(0, 16'h4000); step(10); wr(0, 16'hC000); step(10);
    wr(0, 16'h8001); step(20); wr(0, 16'h4001); step(30);
    wr(0, 16'h4002); step(30);
    for (int i = 0; i < 4000; i++) begin
      int r;
      r = $urandom_range(0, 99);
      tag = (m_mode == 0) ? "R1" : (m_mode == 1) ? "R2" : (m_mode == 2) ? "R3" : "R4";
      if (r < 5) begin
        logic [15:0] d;
        d = 16'($urandom);
        d[12:10] = 3'($urandom_range(0, 1));
        d[9:7] = 3'($urandom_range(0, 2));
        if ($urandom_range(0, 3) != 0) d[15:14] = 2'b11;
        wr(0, d);
      end else if (r < 9) begin
        wr(1, 16'($urandom_range(0, 15)));
      end else begin
        step(1);
      end
    end
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule